// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Voting

This block receives asynchronous serial frames on a single line that idles high. An external tick enable, pulsed at 16 times the bit rate, paces the receiver. A double-speed select changes the pace to 8 ticks per bit. The line passes through a two-flop synchronizer before any sample is taken.

After a falling edge, the start bit has to pass the same three-sample vote at its centre that every later bit uses. A start that votes high is discarded as a spike, and the receiver goes back to hunting for the next falling edge. Every accepted start resets the sampling phase. The receiver then recovers 5 to 8 data bits, least significant bit first, and an optional parity bit. It examines only the first stop bit.

A completed frame is reported by a one-cycle valid strobe. The strobe comes with the data word, a frame-error flag and a parity-error flag, and all three hold until the next frame completes. The receiver starts hunting for the next start edge on the tick right after the stop bit's last voting sample, so it accepts a following frame that begins before a full stop bit has elapsed.

Top module: `uart_rx_os`

## Requirements
- R1: The receiver advances only on clock cycles where `tickEn` is high. A bit lasts 16 ticks when `fastMode` is 0 and 8 ticks when `fastMode` is 1. Cycles with `tickEn` low do not disturb reception.
- R2: Tick phases are counted from 0, where phase 0 is the first low sample of the start bit. Each bit's value is the majority of its samples at phases 7, 8 and 9 (normal speed) or 3, 4 and 5 (double speed). A disturbance on one of those samples leaves the bit unchanged. A disturbance on two of them flips the bit.
- R3: A falling edge whose start-bit vote is high is rejected. No frame is reported, and the receiver resumes hunting for a falling edge.
- R4: `lenCode` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits arrive least significant first and fill `rxData` from bit 0 upward. `rxData` bits above the selected length read 0.
- R5: When `parEn` is 1, a parity bit follows the data. `parOdd`=0 selects even parity, where the data bits plus the parity bit hold an even number of ones. `parOdd`=1 selects odd parity. A mismatch sets `parityErr` alongside `rxValid`. When `parEn` is 0, `parityErr` is 0.
- R6: Only the first stop bit is voted. A voted 0 sets `frameErr` for that frame, and a voted 1 clears it.
- R7: Each frame gives exactly one single-cycle `rxValid` pulse. `rxData`, `frameErr` and `parityErr` change only with that pulse and hold in between.
- R8: Start detection re-arms on the tick after the stop bit's last voting sample. This is tick phase 10 of the stop bit at normal speed and phase 6 at double speed. A new start bit beginning at that phase is received correctly.
- R9: Reset, asynchronous and active low, clears `rxData`, `rxValid`, `frameErr` and `parityErr` to 0. It abandons any frame in progress, and the abandoned frame produces no `rxValid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Oversampling tick, one cycle wide |
| fastMode | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| lenCode | input | 2 | Data length, number of bits = 5 + lenCode |
| parEn | input | 1 | Parity bit present |
| parOdd | input | 1 | 1: odd parity, 0: even parity |
| serialIn | input | 1 | Serial line, idles high |
| rxData | output | 8 | Received data word, zero-extended |
| rxValid | output | 1 | One-cycle strobe per completed frame |
| frameErr | output | 1 | First stop bit voted low |
| parityErr | output | 1 | Parity mismatch on the last frame |

## Verification
A phase counter that drifts by a single tick moves the voting window. This shows up within one frame, either as a flipped data bit when a glitch pair is placed at the centre of a bit, or as a missed start when frames follow each other at the earliest re-arm point. A wrong bit index or length decode appears in `rxData` on the very next strobe, in a shifted or truncated word. A state machine that fails to reject a spike, or leaves the stop state too late, gives an extra or a missing `rxValid` pulse in the frame count taken a few bit times later.

// File: rtl/uart_rx_os_pkg.sv
package uart_rx_os_pkg;

  typedef enum logic [2:0] {
    ST_HUNT   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } rxState_e;

  // strobes from control to datapath, all qualified by tickEn
  typedef struct packed {
    logic sampleEn;    // capture an early voting sample
    logic voteNow;     // last voting sample of the current bit
    logic clearWord;   // new frame accepted edge
    logic storeData;   // write voted bit into the data word
    logic storeParity; // write voted bit into the parity holder
    logic finish;      // stop bit voted, publish frame
  } rxStrobe_t;

endpackage

// File: rtl/uart_rx_os_ctrl.sv
module uart_rx_os_ctrl
  import uart_rx_os_pkg::*;
#(
  parameter int OSR_NORM = 16,
  parameter int OSR_FAST = 8,
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                fastMode,
  input  logic [LEN_W-1:0]    lenCode,
  input  logic                parEn,
  input  logic                lineLow,
  input  logic                voteBit,
  output rxStrobe_t           strobe,
  output logic [IDXW-1:0]     bitIdx
);

  localparam int PHW   = $clog2(OSR_NORM);
  localparam int IDXW  = $clog2(MAX_BITS);
  localparam int LEN_W = $clog2(MAX_BITS - MIN_BITS + 1);

  rxState_e        state;
  logic [PHW-1:0]  phase;
  logic [PHW-1:0]  phaseLast;
  logic [PHW-1:0]  voteFirst;
  logic [PHW-1:0]  voteLast;
  logic [IDXW-1:0] lastIdx;
  logic            bitEnd;
  logic            inFrame;
  logic            inWindow;

  assign phaseLast = fastMode ? PHW'(OSR_FAST - 1)     : PHW'(OSR_NORM - 1);
  assign voteFirst = fastMode ? PHW'(OSR_FAST / 2 - 1) : PHW'(OSR_NORM / 2 - 1);
  assign voteLast  = fastMode ? PHW'(OSR_FAST / 2 + 1) : PHW'(OSR_NORM / 2 + 1);
  assign lastIdx   = IDXW'(MIN_BITS - 1) + IDXW'(lenCode);
  assign bitEnd    = (phase == phaseLast);
  assign inFrame   = tickEn && (state != ST_HUNT);
  assign inWindow  = (phase >= voteFirst) && (phase <= voteLast);

  always_comb begin
    strobe             = '0;
    strobe.sampleEn    = inFrame && inWindow && (phase != voteLast);
    strobe.voteNow     = inFrame && (phase == voteLast);
    strobe.clearWord   = tickEn && (state == ST_HUNT) && lineLow;
    strobe.storeData   = strobe.voteNow && (state == ST_DATA);
    strobe.storeParity = strobe.voteNow && (state == ST_PARITY);
    strobe.finish      = strobe.voteNow && (state == ST_STOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_HUNT;
      phase  <= '0;
      bitIdx <= '0;
    end else if (tickEn) begin
      unique case (state)
        ST_HUNT: begin
          if (lineLow) begin
            state <= ST_START;
            phase <= PHW'(1);
          end
        end
        ST_START: begin
          if ((phase == voteLast) && voteBit) begin
            state <= ST_HUNT;
            phase <= '0;
          end else if (bitEnd) begin
            state  <= ST_DATA;
            phase  <= '0;
            bitIdx <= '0;
          end else begin
            phase <= phase + PHW'(1);
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            phase <= '0;
            if (bitIdx == lastIdx) state <= parEn ? ST_PARITY : ST_STOP;
            else                   bitIdx <= bitIdx + IDXW'(1);
          end else begin
            phase <= phase + PHW'(1);
          end
        end
        ST_PARITY: begin
          if (bitEnd) begin
            state <= ST_STOP;
            phase <= '0;
          end else begin
            phase <= phase + PHW'(1);
          end
        end
        ST_STOP: begin
          if (phase == voteLast) begin
            state <= ST_HUNT;
            phase <= '0;
          end else begin
            phase <= phase + PHW'(1);
          end
        end
        default: begin
          state <= ST_HUNT;
          phase <= '0;
        end
      endcase
    end
  end

  // R1: nothing moves between ticks
  p_freeze_r1: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> ($stable(state) && $stable(phase)));

  // R1: phase stays inside the bit length of the selected speed
  p_phase_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_HUNT) |-> (phase <= phaseLast));

  // R3: a start bit voted high returns to hunting
  p_spike_reject_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && state == ST_START && phase == voteLast && voteBit) |=> (state == ST_HUNT));

  // R4: the bit index never runs past the selected length
  p_bit_index_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitIdx <= lastIdx));

  // R8: hunting resumes right after the stop vote
  p_rearm_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && state == ST_STOP && phase == voteLast) |=> (state == ST_HUNT));

endmodule

// File: rtl/uart_rx_os_dp.sv
module uart_rx_os_dp
  import uart_rx_os_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serialIn,
  input  logic                 parEn,
  input  logic                 parOdd,
  input  rxStrobe_t            strobe,
  input  logic [IDXW-1:0]      bitIdx,
  output logic                 lineLow,
  output logic                 voteBit,
  output logic [MAX_BITS-1:0]  rxData,
  output logic                 rxValid,
  output logic                 frameErr,
  output logic                 parityErr
);

  localparam int IDXW = $clog2(MAX_BITS);

  logic                syncMeta;
  logic                rxSync;
  logic                sampA;
  logic                sampB;
  logic                parBit;
  logic [MAX_BITS-1:0] word;

  // two-flop synchronizer, line idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= 1'b1;
      rxSync   <= 1'b1;
    end else begin
      syncMeta <= serialIn;
      rxSync   <= syncMeta;
    end
  end

  assign lineLow = !rxSync;
  assign voteBit = (sampA & sampB) | (sampA & rxSync) | (sampB & rxSync);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampA  <= 1'b1;
      sampB  <= 1'b1;
      parBit <= 1'b0;
      word   <= '0;
    end else begin
      if (strobe.sampleEn) begin
        sampB <= sampA;
        sampA <= rxSync;
      end
      if (strobe.clearWord)   word         <= '0;
      if (strobe.storeData)   word[bitIdx] <= voteBit;
      if (strobe.storeParity) parBit       <= voteBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      rxValid   <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
    end else begin
      rxValid <= strobe.finish;
      if (strobe.finish) begin
        rxData    <= word;
        frameErr  <= !voteBit;
        parityErr <= parEn && ((^word ^ parBit) != parOdd);
      end
    end
  end

  // R7: strobe is one cycle wide
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R7: outputs change only with the strobe
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !($stable(rxData) && $stable(frameErr) && $stable(parityErr)) |-> rxValid);

  // R6: stop vote decides the frame error
  p_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> (rxValid && (frameErr == !$past(voteBit))));

  // R5: no parity error without a parity bit
  p_no_parity_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !$past(parEn)) |-> !parityErr);

endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os
  import uart_rx_os_pkg::*;
#(
  parameter int OSR_NORM = 16,
  parameter int OSR_FAST = 8,
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                fastMode,
  input  logic [LEN_W-1:0]    lenCode,
  input  logic                parEn,
  input  logic                parOdd,
  input  logic                serialIn,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxValid,
  output logic                frameErr,
  output logic                parityErr
);

  localparam int IDXW  = $clog2(MAX_BITS);
  localparam int LEN_W = $clog2(MAX_BITS - MIN_BITS + 1);

  rxStrobe_t       strobe;
  logic [IDXW-1:0] bitIdx;
  logic            lineLow;
  logic            voteBit;

  uart_rx_os_ctrl #(
    .OSR_NORM(OSR_NORM),
    .OSR_FAST(OSR_FAST),
    .MIN_BITS(MIN_BITS),
    .MAX_BITS(MAX_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .fastMode (fastMode),
    .lenCode  (lenCode),
    .parEn    (parEn),
    .lineLow  (lineLow),
    .voteBit  (voteBit),
    .strobe   (strobe),
    .bitIdx   (bitIdx)
  );

  uart_rx_os_dp #(
    .MAX_BITS(MAX_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .parEn     (parEn),
    .parOdd    (parOdd),
    .strobe    (strobe),
    .bitIdx    (bitIdx),
    .lineLow   (lineLow),
    .voteBit   (voteBit),
    .rxData    (rxData),
    .rxValid   (rxValid),
    .frameErr  (frameErr),
    .parityErr (parityErr)
  );

endmodule

// File: tb/uart_rx_os_tb.sv
`timescale 1ns/1ps
module uart_rx_os_tb;

  typedef struct packed {
    logic [1:0] div;
    logic       fast;
    logic [1:0] len;
    logic       pEn;
    logic       pOdd;
    logic       stopBad;
    logic       pFlip;
    logic [7:0] data;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    '{2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h13},
    '{2'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5A},
    '{2'd2, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C},
    '{2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h2B},
    '{2'd0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF},
    '{2'd0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00},
    '{2'd1, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h81},
    '{2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       tickEn;
  logic       fastMode;
  logic [1:0] lenCode;
  logic       parEn;
  logic       parOdd;
  logic       serialIn;
  logic [7:0] rxData;
  logic       rxValid;
  logic       frameErr;
  logic       parityErr;

  int checks   = 0;
  int failures = 0;
  int div      = 1;
  int nFrames  = 0;
  bit done     = 1'b0;
  logic [7:0] logData [32];
  logic       logFe   [32];
  logic       logPe   [32];

  always #2.5 clk = ~clk;

  uart_rx_os u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .fastMode(fastMode),
    .lenCode(lenCode), .parEn(parEn), .parOdd(parOdd), .serialIn(serialIn),
    .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr), .parityErr(parityErr)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      logData[nFrames % 32] = rxData;
      logFe[nFrames % 32]   = frameErr;
      logPe[nFrames % 32]   = parityErr;
      nFrames++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic oneTick();
    if (div > 1) repeat (div - 1) begin @(negedge clk); tickEn = 1'b0; end
    @(negedge clk);
    tickEn = 1'b1;
  endtask

  task automatic hold(input int n, input logic v);
    serialIn = v;
    repeat (n) oneTick();
  endtask

  function automatic int bitTicks();
    return fastMode ? 8 : 16;
  endfunction

  task automatic sendFrame(input logic [7:0] d, input int nb, input bit pFlip,
                           input bit stopBad, input int stopLen, input int glitch);
    int bt;
    logic [7:0] m;
    logic pbit;
    bt = bitTicks();
    m = 8'((1 << nb) - 1);
    hold(bt, 1'b0);
    for (int i = 0; i < nb; i++) begin
      if (i == 0 && glitch > 0) begin
        hold(bt / 2, d[i]);
        hold(glitch, ~d[i]);
        hold(bt - bt / 2 - glitch, d[i]);
      end else begin
        hold(bt, d[i]);
      end
    end
    if (parEn) begin
      pbit = (^(d & m)) ^ parOdd ^ pFlip;
      hold(bt, pbit);
    end
    hold(stopLen, !stopBad);
    serialIn = 1'b1;
  endtask

  task automatic expectOne(input int base, input string req, input logic [7:0] expD,
                           input logic expFe, input logic expPe);
    check(nFrames == base + 1, "R7", "frame count", nFrames, base + 1);
    check(logData[base % 32] == expD, req, "data", int'(logData[base % 32]), int'(expD));
    check(logFe[base % 32] == expFe, "R6", "frameErr", int'(logFe[base % 32]), int'(expFe));
    check(logPe[base % 32] == expPe, "R5", "parityErr", int'(logPe[base % 32]), int'(expPe));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    rstN = 1'b0; tickEn = 1'b1; fastMode = 1'b0; lenCode = 2'd3;
    parEn = 1'b0; parOdd = 1'b0; serialIn = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(rxData == 8'h00, "R9", "rxData after reset", int'(rxData), 0);
    check(rxValid == 1'b0, "R9", "rxValid after reset", int'(rxValid), 0);
    check(frameErr == 1'b0, "R9", "frameErr after reset", int'(frameErr), 0);
    check(parityErr == 1'b0, "R9", "parityErr after reset", int'(parityErr), 0);
    rstN = 1'b1;
    hold(20, 1'b1);

    // vector table: R1 (tick spacing), R4, R5, R6, R7
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [7:0] expD;
      t = VECS[v];
      div = int'(t.div) + 1;
      fastMode = t.fast; lenCode = t.len; parEn = t.pEn; parOdd = t.pOdd;
      hold(4, 1'b1);
      base = nFrames;
      sendFrame(t.data, 5 + int'(t.len), t.pFlip, t.stopBad, bitTicks(), 0);
      hold(3 * bitTicks(), 1'b1);
      expD = t.data & 8'((1 << (5 + int'(t.len))) - 1);
      expectOne(base, (t.div != 0) ? "R1" : "R4", expD, t.stopBad, t.pEn & t.pFlip);
    end

    div = 1; lenCode = 2'd3; parEn = 1'b0; parOdd = 1'b0;

    // R3: spikes rejected by the start vote
    fastMode = 1'b0;
    base = nFrames; hold(4, 1'b0); hold(40, 1'b1);
    check(nFrames == base, "R3", "4-tick spike normal", nFrames, base);
    base = nFrames; hold(8, 1'b0); hold(40, 1'b1);
    check(nFrames == base, "R3", "8-tick spike normal", nFrames, base);
    fastMode = 1'b1;
    base = nFrames; hold(4, 1'b0); hold(30, 1'b1);
    check(nFrames == base, "R3", "4-tick spike fast", nFrames, base);
    base = nFrames;
    sendFrame(8'h96, 8, 1'b0, 1'b0, bitTicks(), 0);
    hold(3 * bitTicks(), 1'b1);
    expectOne(base, "R3", 8'h96, 1'b0, 1'b0);

    // R2: single-sample disturbance filtered, two-sample disturbance wins
    fastMode = 1'b0;
    base = nFrames;
    sendFrame(8'h55, 8, 1'b0, 1'b0, 16, 1);
    hold(48, 1'b1);
    expectOne(base, "R2", 8'h55, 1'b0, 1'b0);
    base = nFrames;
    sendFrame(8'h55, 8, 1'b0, 1'b0, 16, 2);
    hold(48, 1'b1);
    expectOne(base, "R2", 8'h54, 1'b0, 1'b0);
    fastMode = 1'b1;
    base = nFrames;
    sendFrame(8'hAA, 8, 1'b0, 1'b0, 8, 1);
    hold(24, 1'b1);
    expectOne(base, "R2", 8'hAA, 1'b0, 1'b0);
    base = nFrames;
    sendFrame(8'hAA, 8, 1'b0, 1'b0, 8, 2);
    hold(24, 1'b1);
    expectOne(base, "R2", 8'hAB, 1'b0, 1'b0);

    // R8: next start at the earliest re-arm phase
    fastMode = 1'b0;
    base = nFrames;
    sendFrame(8'h3A, 8, 1'b0, 1'b0, 10, 0);
    sendFrame(8'hC5, 8, 1'b0, 1'b0, 16, 0);
    hold(48, 1'b1);
    check(nFrames == base + 2, "R8", "frames normal", nFrames, base + 2);
    check(logData[base % 32] == 8'h3A, "R8", "first normal", int'(logData[base % 32]), 'h3A);
    check(logData[(base + 1) % 32] == 8'hC5, "R8", "second normal",
          int'(logData[(base + 1) % 32]), 'hC5);
    check(logFe[base % 32] == 1'b0, "R8", "short stop no frameErr", int'(logFe[base % 32]), 0);
    fastMode = 1'b1;
    base = nFrames;
    sendFrame(8'h6E, 8, 1'b0, 1'b0, 6, 0);
    sendFrame(8'h91, 8, 1'b0, 1'b0, 8, 0);
    hold(24, 1'b1);
    check(nFrames == base + 2, "R8", "frames fast", nFrames, base + 2);
    check(logData[base % 32] == 8'h6E, "R8", "first fast", int'(logData[base % 32]), 'h6E);
    check(logData[(base + 1) % 32] == 8'h91, "R8", "second fast",
          int'(logData[(base + 1) % 32]), 'h91);

    // R9: reset in the middle of a frame
    fastMode = 1'b0;
    base = nFrames;
    hold(16, 1'b0); hold(16, 1'b1); hold(8, 1'b0);
    @(negedge clk); rstN = 1'b0; serialIn = 1'b1;
    repeat (3) @(negedge clk);
    check(rxData == 8'h00, "R9", "rxData mid-frame reset", int'(rxData), 0);
    check(frameErr == 1'b0 && parityErr == 1'b0, "R9", "flags mid-frame reset",
          int'({frameErr, parityErr}), 0);
    rstN = 1'b1;
    hold(200, 1'b1);
    check(nFrames == base, "R9", "aborted frame not reported", nFrames, base);
    sendFrame(8'h7D, 8, 1'b0, 1'b0, 16, 0);
    hold(48, 1'b1);
    expectOne(base, "R9", 8'h7D, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule